// File: doc/BRIEF.md
# Daisy-Chain Serial Configuration Receiver

This block is the serial front end of a device that loads its configuration through a daisy chain. Every device on the chain shares one configuration clock. A header travels down the whole chain. It opens with a fixed four-bit pattern and carries a 24-bit length count. The receiver watches the serial input for that pattern and shifts in the length count. While it does so, it passes every header bit to the next device.

After the header, the receiver takes its own fixed number of data frames. During that time it drives its serial output High, so the downstream devices see only idle. Once its own frames are in, it copies every later bit straight through to the next device.

The receiver also counts configuration clocks from reset. All devices hold the same length count and see the same clock, so they all reach a count match on the same edge. At that edge the receiver raises done. It enters start-up one clock later and releases user I/O one clock after that. If the match arrives before its own frames are complete, it raises an error flag, and start-up still goes ahead.

Top module: `cfg_chain_rx`

## Requirements
- R1: While reset is asserted, `sdo` is 1 and `done`, `startup`, `io_rel` and `lc_err` are 0.
- R2: The header begins at the first point after reset where the last four input bits, oldest first, read 0,0,1,0. Every bit up to and including that point appears on `sdo` one clock after it is sampled.
- R3: The 24 bits after the pattern are the length count, MSB first. Each of these bits also appears on `sdo` one clock after it is sampled.
- R4: After the length count, `sdo` is 1 for every sampled bit until this device has taken FRAMES frames. A frame is one 0 start bit followed by FRAME_BITS data bits. Any 1 bits between frames are skipped.
- R5: After the last bit of the device's own last frame, every sampled bit appears on `sdo` one clock later.
- R6: A clock counter starts at 0 at reset and increases by one on each rising edge. `done` becomes 1 right after the edge on which the count equals the captured length count.
- R7: `startup` becomes 1 one clock after `done`, and `io_rel` becomes 1 two clocks after `done`.
- R8: Once set, `done`, `startup`, `io_rel` and `lc_err` stay 1 until the next reset.
- R9: `lc_err` rises together with `done` if the count match comes before the last bit of the device's own frames. A match on the same edge as that last bit is not an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared configuration clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sdi | input | 1 | Serial data from the previous device; idle High |
| sdo | output | 1 | Registered serial data to the next device |
| done | output | 1 | Length-count match reached |
| startup | output | 1 | Start-up sequence entered |
| io_rel | output | 1 | User I/O released |
| lc_err | output | 1 | Count matched before own frames were complete |

## Verification
Two events can fall on the same clock edge: the count match and the last bit of the device's own frames. The bench sweeps the length count from three clocks before that last bit to three clocks after it, and it varies the idle gaps before each frame, so the match lands before, on and after the frame end.

For every sampled bit, the bench works out from bit positions alone which region the bit belongs to (header, own frames or forwarded data). It then checks `sdo` against that region. It also checks the status outputs against the edge number and the length count. The error flag is expected only when the length count is strictly smaller than the edge number of the last own bit.

// File: rtl/cfg_chain_rx.sv
module cfg_chain_rx #(
  parameter int FRAMES     = 4,
  parameter int FRAME_BITS = 32,
  parameter int LC_W       = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sdi,
  output logic sdo,
  output logic done,
  output logic startup,
  output logic io_rel,
  output logic lc_err
);
  localparam int FBW = $clog2(FRAME_BITS + 1);
  localparam int FCW = $clog2(FRAMES + 1);
  localparam int LBW = $clog2(LC_W + 1);

  typedef enum logic [1:0] {HUNT, LEN, OWN, FWD} st_t;

  st_t            st;
  logic [2:0]     sh;
  logic [LC_W-1:0] lc, cnt;
  logic [LBW-1:0] lbit;
  logic [FBW-1:0] fb;
  logic [FCW-1:0] fc;
  logic           in_fr;

  wire [LC_W-1:0] cnt_nxt  = cnt + 1'b1;
  wire            fr_last  = in_fr && fb == FBW'(FRAME_BITS - 1);
  wire            own_last = st == OWN && fr_last && fc == FCW'(FRAMES - 1);
  wire            match    = !done && (st == OWN || st == FWD) && cnt_nxt == lc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= HUNT;
      sh      <= '1;
      lc      <= '0;
      cnt     <= '0;
      lbit    <= '0;
      fb      <= '0;
      fc      <= '0;
      in_fr   <= 1'b0;
      sdo     <= 1'b1;
      done    <= 1'b0;
      startup <= 1'b0;
      io_rel  <= 1'b0;
      lc_err  <= 1'b0;
    end else begin
      sh      <= {sh[1:0], sdi};
      sdo     <= (st == OWN) ? 1'b1 : sdi;
      startup <= startup | done;
      io_rel  <= io_rel | startup;
      if (!done) cnt <= cnt_nxt;
      case (st)
        HUNT: if ({sh, sdi} == 4'b0010) begin
          st   <= LEN;
          lbit <= '0;
        end
        LEN: begin
          lc   <= {lc[LC_W-2:0], sdi};
          lbit <= lbit + 1'b1;
          if (lbit == LBW'(LC_W - 1)) st <= OWN;
        end
        OWN: begin
          if (!in_fr) begin
            if (!sdi) begin
              in_fr <= 1'b1;
              fb    <= '0;
            end
          end else begin
            fb <= fb + 1'b1;
            if (fr_last) begin
              in_fr <= 1'b0;
              fc    <= fc + 1'b1;
              if (own_last) st <= FWD;
            end
          end
        end
        default: ;
      endcase
      if (match) begin
        done <= 1'b1;
        if (st == OWN && !own_last) lc_err <= 1'b1;
      end
    end
  end

  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lc_err |=> lc_err);
  a_r6_done_at_count: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> cnt == lc);
  a_r7_startup_follows_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(startup) |-> $past(done));
  a_r7_io_follows_startup: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_rel) |-> $past(startup));
  a_r4_own_holds_high: assert property (@(posedge clk) disable iff (!rst_n)
    st == OWN |=> sdo);
  a_r5_forward_copy: assert property (@(posedge clk) disable iff (!rst_n)
    st == FWD |=> sdo == $past(sdi));
  a_r9_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lc_err) |-> $rose(done));
endmodule

// File: tb/cfg_chain_rx_bench.sv
module cfg_chain_rx_bench;
  localparam int FR = 2, FB = 4, MAXN = 128;
  logic clk = 1'b0, rst_n = 1'b0, sdi = 1'b1;
  logic sdo, done, startup, io_rel, lc_err;
  int checks = 0, errors = 0;
  bit finished = 0;
  logic strm [1:MAXN];

  always #10 clk = ~clk;

  cfg_chain_rx #(.FRAMES(FR), .FRAME_BITS(FB), .LC_W(24)) u_cfg_chain_rx (
    .clk(clk), .rst_n(rst_n), .sdi(sdi), .sdo(sdo), .done(done),
    .startup(startup), .io_rel(io_rel), .lc_err(lc_err));

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic run(input int g1, input int g2, input int lcoff);
    int p, h, e, lc, n;
    p = 0;
    strm[1] = 1; strm[2] = 1; strm[3] = 0; strm[4] = 1;
    strm[5] = 0; strm[6] = 0; strm[7] = 1; strm[8] = 0;
    p = 8; h = p + 24;
    e = h + g1 + 1 + FB + g2 + 1 + FB;
    lc = e + lcoff;
    n = lc + 6;
    for (int k = 23; k >= 0; k--) begin p++; strm[p] = lc[k]; end
    for (int k = 0; k < g1; k++) begin p++; strm[p] = 1; end
    p++; strm[p] = 0;
    for (int k = 0; k < FB; k++) begin p++; strm[p] = ((k + g1) % 3 == 0); end
    for (int k = 0; k < g2; k++) begin p++; strm[p] = 1; end
    p++; strm[p] = 0;
    for (int k = 0; k < FB; k++) begin p++; strm[p] = ((k + g2) % 2 == 0); end
    for (int j = p + 1; j <= n; j++) strm[j] = ((j * 5 + g1) % 3 != 0);

    @(negedge clk); rst_n = 1'b0; sdi = 1'b1;
    @(negedge clk);
    chk("R1", "sdo", sdo, 1'b1);
    chk("R1", "done", done, 1'b0);
    chk("R1", "startup", startup, 1'b0);
    chk("R1", "io_rel", io_rel, 1'b0);
    chk("R1", "lc_err", lc_err, 1'b0);
    rst_n = 1'b1;
    for (int j = 1; j <= n; j++) begin
      sdi = strm[j];
      @(posedge clk);
      @(negedge clk);
      if (j <= 8)      chk("R2", "sdo header", sdo, strm[j]);
      else if (j <= h) chk("R3", "sdo length", sdo, strm[j]);
      else if (j <= e) chk("R4", "sdo own", sdo, 1'b1);
      else             chk("R5", "sdo forward", sdo, strm[j]);
      chk("R6", "done", done, j >= lc);
      chk("R7", "startup", startup, j >= lc + 1);
      chk(j > lc + 2 ? "R8" : "R7", "io_rel", io_rel, j >= lc + 2);
      chk(j > lc ? "R8" : "R9", "lc_err", lc_err, (j >= lc) && (lc < e));
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    for (int g1 = 0; g1 <= 2; g1++)
      for (int g2 = 0; g2 <= 1; g2++)
        for (int o = -3; o <= 3; o++)
          run(g1, g2, o);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule